// File: doc/BRIEF.md
# Pixel Depth Reducer and Range Clamp

This block is one stage of a display output formatter. It accepts a stream of pixels with three components of 12 bits each. It reduces every component to a narrower depth of 6, 8 or 10 bits. The reduction either discards the low bits or rounds to the nearest code of the target depth. It then limits each component to a legal window. The window is either a fixed limited-range window tied to an 8-, 10- or 12-bit grid, or a per-component window given by configuration inputs.

Pixels move over a valid/ready handshake on both sides. Each pixel passes through two register stages, one after the reduction and one after the clamp. The configuration inputs are static: they are changed only while no pixel is inside the stage. A reduced component stays MSB-aligned in its 12-bit lane, and the bits below the kept depth read zero. A pixel word packs red in bits [35:24], green in bits [23:12] and blue in bits [11:0]. The two limit inputs use the same packing.

Top module: `pix_depth_clamp`

## Requirements
- R1: With `cfg_red_en` low and clamp mode 0, every component leaves the stage equal to its input.
- R2: With `cfg_red_en` high, depth code 0 keeps the top 6 bits, 1 the top 8 and 2 the top 10; the bits below are zero; code 3 leaves the component unreduced.
- R3: With `cfg_red_round` low, reduction drops the low bits without changing the kept bits.
- R4: With `cfg_red_round` high, half an LSB of the target depth is added before the low bits are dropped; a carry out of bit 11 gives the all-ones code of the target depth instead of wrapping.
- R5: Clamp mode 0 applies no limit; modes 5, 6 and 7 behave the same way.
- R6: Clamp mode 1 compares bits [11:4] with 0x01..0xFE; a component below the window becomes 0x010, one above it becomes 0xFE0, and one inside it is unchanged.
- R7: Clamp mode 2 compares bits [11:2] with 0x004..0x3FB; a component below the window becomes 0x010, one above it becomes 0xFEC, and one inside it is unchanged.
- R8: Clamp mode 3 limits the full 12-bit component to 0x010..0xFEF.
- R9: Clamp mode 4 limits each component to its own lower and upper limit from `cfg_clamp_lo` and `cfg_clamp_hi`. The lower limit is applied first.
- R10: A pixel accepted at one clock edge is presented on the output after the second following edge when `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output holds still. No pixel is lost or duplicated.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_red_en | input | 1 | Enables depth reduction |
| cfg_red_depth | input | 2 | Target depth code: 0=6, 1=8, 2=10 bits, 3=none |
| cfg_red_round | input | 1 | 1 = round, 0 = truncate |
| cfg_clamp_mode | input | 3 | 0 full, 1 8-bit window, 2 10-bit window, 3 12-bit window, 4 programmable |
| cfg_clamp_lo | input | 36 | Per-component lower limits, packed R,G,B |
| cfg_clamp_hi | input | 36 | Per-component upper limits, packed R,G,B |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can take a pixel |
| in_pix | input | 36 | Input pixel, packed R,G,B |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pix | output | 36 | Output pixel, packed R,G,B |

## Verification
The assertions take for granted that the configuration inputs stay constant whenever a pixel is inside the stage. The checks that tie the output bits to a mode rely on this, because they read the present configuration against an older pixel. The programmable-window check also relies on each lower limit being no greater than its upper limit. The bench changes the configuration only after the previous pixel has left and `out_valid` has dropped. It keeps the limits ordered and holds the configuration fixed during the streaming and backpressure runs.

// File: rtl/pdc_pkg.sv
// Package: shared encodings for the pixel depth reducer and clamp.
// Assumes components are 12 bits wide for the fixed window constants.
package pdc_pkg;

    typedef enum logic [2:0] {
        CLMP_NONE  = 3'd0,
        CLMP_WIN8  = 3'd1,
        CLMP_WIN10 = 3'd2,
        CLMP_WIN12 = 3'd3,
        CLMP_PROG  = 3'd4
    } clamp_sel_e;

    typedef enum logic [1:0] {
        KEEP6  = 2'd0,
        KEEP8  = 2'd1,
        KEEP10 = 2'd2,
        KEEP_ALL = 2'd3
    } depth_sel_e;

endpackage

// File: rtl/pdc_reduce.sv
// Module: pdc_reduce
// Reduces one component to 6, 8 or 10 MSB-aligned bits by truncation or
// rounding with saturation. Purely combinational. Assumes COMP_W > 10.
module pdc_reduce #(
    parameter int COMP_W = 12
) (
    input  logic              en_i,
    input  logic [1:0]        depth_i,
    input  logic              round_i,
    input  logic [COMP_W-1:0] comp_i,
    output logic [COMP_W-1:0] comp_o
);
    import pdc_pkg::*;

    localparam int DROP6  = COMP_W - 6;
    localparam int DROP8  = COMP_W - 8;
    localparam int DROP10 = COMP_W - 10;

    int                drop;
    logic [COMP_W-1:0] keep_mask;
    logic [COMP_W:0]   half;
    logic [COMP_W:0]   sum;

    // Purpose: pick the number of discarded bits from the depth code.
    always_comb begin
        unique case (depth_sel_e'(depth_i))
            KEEP6:   drop = DROP6;
            KEEP8:   drop = DROP8;
            KEEP10:  drop = DROP10;
            default: drop = 0;
        endcase
        if (!en_i) drop = 0;
    end

    // Purpose: form the mask, add the rounding offset and saturate.
    always_comb begin
        keep_mask = {COMP_W{1'b1}} << drop;
        half = '0;
        if (round_i && drop > 0) half[drop-1] = 1'b1;
        sum = {1'b0, comp_i} + half;
        if (sum[COMP_W]) comp_o = keep_mask;
        else             comp_o = sum[COMP_W-1:0] & keep_mask;
    end

endmodule

// File: rtl/pdc_clamp.sv
// Module: pdc_clamp
// Limits one component to a fixed window on an 8-, 10- or 12-bit grid or to
// a programmable window. Combinational. Assumes COMP_W == 12 for the fixed windows.
module pdc_clamp #(
    parameter int COMP_W = 12
) (
    input  logic [2:0]        mode_i,
    input  logic [COMP_W-1:0] lo_i,
    input  logic [COMP_W-1:0] hi_i,
    input  logic [COMP_W-1:0] comp_i,
    output logic [COMP_W-1:0] comp_o
);
    import pdc_pkg::*;

    localparam int SH8  = COMP_W - 8;
    localparam int SH10 = COMP_W - 10;

    localparam logic [COMP_W-1:0] W8_LO  = COMP_W'(12'h001) << SH8;
    localparam logic [COMP_W-1:0] W8_HI  = COMP_W'(12'h0FE) << SH8;
    localparam logic [COMP_W-1:0] W10_LO = COMP_W'(12'h004) << SH10;
    localparam logic [COMP_W-1:0] W10_HI = COMP_W'(12'h3FB) << SH10;
    localparam logic [COMP_W-1:0] W12_LO = COMP_W'(12'h010);
    localparam logic [COMP_W-1:0] W12_HI = COMP_W'(12'hFEF);

    logic [7:0] top8;
    logic [9:0] top10;

    assign top8  = comp_i[COMP_W-1 -: 8];
    assign top10 = comp_i[COMP_W-1 -: 10];

    // Purpose: select the window for the mode and apply it.
    always_comb begin
        comp_o = comp_i;
        unique case (clamp_sel_e'(mode_i))
            CLMP_WIN8: begin
                if (top8 < 8'h01)      comp_o = W8_LO;
                else if (top8 > 8'hFE) comp_o = W8_HI;
            end
            CLMP_WIN10: begin
                if (top10 < 10'h004)      comp_o = W10_LO;
                else if (top10 > 10'h3FB) comp_o = W10_HI;
            end
            CLMP_WIN12: begin
                if (comp_i < W12_LO)      comp_o = W12_LO;
                else if (comp_i > W12_HI) comp_o = W12_HI;
            end
            CLMP_PROG: begin
                if (comp_i < lo_i)        comp_o = lo_i;
                else if (comp_i > hi_i)   comp_o = hi_i;
            end
            default: comp_o = comp_i;
        endcase
    end

    // Purpose: programmable window result lies inside ordered limits.
    always_comb begin
        if (mode_i == 3'd4 && lo_i <= hi_i) begin
            AST_PROG_WINDOW: assert (comp_o >= lo_i && comp_o <= hi_i) else $error("prog window"); // R9
        end
    end

endmodule

// File: rtl/pix_depth_clamp.sv
// Module: pix_depth_clamp
// Two-stage pixel pipeline: stage 1 registers the depth-reduced pixel, stage 2
// registers the clamped pixel. Valid/ready on both sides. Assumes the cfg_*
// inputs stay constant while any pixel is in flight.
module pix_depth_clamp #(
    parameter int COMP_W = 12,
    parameter int NCOMP  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_red_en,
    input  logic [1:0]                cfg_red_depth,
    input  logic                      cfg_red_round,
    input  logic [2:0]                cfg_clamp_mode,
    input  logic [COMP_W*NCOMP-1:0]   cfg_clamp_lo,
    input  logic [COMP_W*NCOMP-1:0]   cfg_clamp_hi,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [COMP_W*NCOMP-1:0]   in_pix,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [COMP_W*NCOMP-1:0]   out_pix
);
    localparam int PIX_W = COMP_W * NCOMP;

    logic             s1_vld, s2_vld;
    logic [PIX_W-1:0] s1_pix, s2_pix;
    logic [PIX_W-1:0] red_pix, clp_pix;
    logic             s1_load, s2_load;

    genvar gi;
    generate
        for (gi = 0; gi < NCOMP; gi++) begin : g_comp
            pdc_reduce #(.COMP_W(COMP_W)) u_red (
                .en_i    (cfg_red_en),
                .depth_i (cfg_red_depth),
                .round_i (cfg_red_round),
                .comp_i  (in_pix[gi*COMP_W +: COMP_W]),
                .comp_o  (red_pix[gi*COMP_W +: COMP_W])
            );
            pdc_clamp #(.COMP_W(COMP_W)) u_clp (
                .mode_i  (cfg_clamp_mode),
                .lo_i    (cfg_clamp_lo[gi*COMP_W +: COMP_W]),
                .hi_i    (cfg_clamp_hi[gi*COMP_W +: COMP_W]),
                .comp_i  (s1_pix[gi*COMP_W +: COMP_W]),
                .comp_o  (clp_pix[gi*COMP_W +: COMP_W])
            );
        end
    endgenerate

    // Purpose: stage load enables from downstream readiness.
    assign s2_load  = !s2_vld || out_ready;
    assign s1_load  = !s1_vld || s2_load;
    assign in_ready = s1_load;

    // Purpose: stage 1 register holds the reduced pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_pix <= '0;
        end else if (s1_load) begin
            s1_vld <= in_valid;
            s1_pix <= red_pix;
        end
    end

    // Purpose: stage 2 register holds the clamped pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_pix <= '0;
        end else if (s2_load) begin
            s2_vld <= s1_vld;
            s2_pix <= clp_pix;
        end
    end

    assign out_valid = s2_vld;
    assign out_pix   = s2_pix;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))) else $error("stall hold"); // R10

    AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 out_ready |=> out_valid) else $error("latency"); // R10

    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready) else $error("empty ready"); // R11

    generate
        for (gi = 0; gi < NCOMP; gi++) begin : g_chk
            AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && cfg_red_en && cfg_red_depth == 2'd0 && cfg_clamp_mode == 3'd0)
                |-> (out_pix[gi*COMP_W +: 6] == 6'd0)) else $error("low bits"); // R2

            AST_WIN8_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && cfg_clamp_mode == 3'd1)
                |-> (out_pix[gi*COMP_W + COMP_W - 8 +: 8] >= 8'h01 &&
                     out_pix[gi*COMP_W + COMP_W - 8 +: 8] <= 8'hFE)) else $error("win8"); // R6

            AST_WIN12_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && cfg_clamp_mode == 3'd3)
                |-> (out_pix[gi*COMP_W +: COMP_W] >= COMP_W'(12'h010) &&
                     out_pix[gi*COMP_W +: COMP_W] <= COMP_W'(12'hFEF))) else $error("win12"); // R8
        end
    endgenerate

endmodule

// File: tb/pix_depth_clamp_tb.sv
// Bench: vector table walked by one loop, then directed reset, latency and
// backpressure tests.
module pix_depth_clamp_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_red_en;
    logic [1:0]  cfg_red_depth;
    logic        cfg_red_round;
    logic [2:0]  cfg_clamp_mode;
    logic [35:0] cfg_clamp_lo, cfg_clamp_hi;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [35:0] in_pix, out_pix;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pix_depth_clamp dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_red_en(cfg_red_en), .cfg_red_depth(cfg_red_depth),
        .cfg_red_round(cfg_red_round), .cfg_clamp_mode(cfg_clamp_mode),
        .cfg_clamp_lo(cfg_clamp_lo), .cfg_clamp_hi(cfg_clamp_hi),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    // Layout: [82:79] req, [78] en, [77:76] depth, [75] round,
    // [74:72] clamp mode, [71:36] input pixel, [35:0] expected pixel.
    localparam int NV = 16;
    localparam logic [82:0] VEC [NV] = '{
        {4'd1, 1'b0, 2'd0, 1'b0, 3'd0, 36'hABC123FFF, 36'hABC123FFF},
        {4'd3, 1'b1, 2'd0, 1'b0, 3'd0, 36'hABC123FFF, 36'hA80100FC0},
        {4'd3, 1'b1, 2'd1, 1'b0, 3'd0, 36'hABC123FFF, 36'hAB0120FF0},
        {4'd2, 1'b1, 2'd2, 1'b0, 3'd0, 36'hABC123FFF, 36'hABC120FFC},
        {4'd2, 1'b1, 2'd3, 1'b0, 3'd0, 36'hABC123FFF, 36'hABC123FFF},
        {4'd4, 1'b1, 2'd1, 1'b1, 3'd0, 36'hABC127128, 36'hAC0120130},
        {4'd4, 1'b1, 2'd0, 1'b1, 3'd0, 36'hFFFFE001F, 36'hFC0FC0000},
        {4'd4, 1'b1, 2'd2, 1'b1, 3'd0, 36'h003001FFE, 36'h004000FFC},
        {4'd6, 1'b0, 2'd0, 1'b0, 3'd1, 36'h005FF3FE5, 36'h010FE0FE5},
        {4'd7, 1'b0, 2'd0, 1'b0, 3'd2, 36'h00FFEDFF0, 36'h010FEDFEC},
        {4'd8, 1'b0, 2'd0, 1'b0, 3'd3, 36'h00FFF0800, 36'h010FEF800},
        {4'd9, 1'b0, 2'd0, 1'b0, 3'd4, 36'h0FFD01500, 36'h100D00500},
        {4'd9, 1'b0, 2'd0, 1'b0, 3'd4, 36'hE011FFC01, 36'hE00200C00},
        {4'd5, 1'b0, 2'd0, 1'b0, 3'd5, 36'h000FFF00F, 36'h000FFF00F},
        {4'd6, 1'b1, 2'd1, 1'b0, 3'd1, 36'hFFF000804, 36'hFE0010800},
        {4'd5, 1'b0, 2'd0, 1'b0, 3'd0, 36'h000FFF001, 36'h000FFF001}
    };

    function automatic string rtag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [35:0] stream [5];
    logic [35:0] got [5];

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_pix = '0;
        cfg_red_en = 1'b0; cfg_red_depth = 2'd0; cfg_red_round = 1'b0;
        cfg_clamp_mode = 3'd0;
        cfg_clamp_lo = 36'h100200300;
        cfg_clamp_hi = 36'hE00D00C00;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "out_valid in reset", {35'd0, out_valid}, 36'd0);
        check("R11", "in_ready in reset", {35'd0, in_ready}, 36'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "out_valid after reset", {35'd0, out_valid}, 36'd0);

        // Table walk: one pixel per vector, pipeline drained between them.
        for (int v = 0; v < NV; v++) begin
            cfg_red_en     = VEC[v][78];
            cfg_red_depth  = VEC[v][77:76];
            cfg_red_round  = VEC[v][75];
            cfg_clamp_mode = VEC[v][74:72];
            in_pix         = VEC[v][71:36];
            in_valid       = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            // R10: not yet visible one edge after acceptance
            check("R10", "valid after one edge", {35'd0, out_valid}, 36'd0);
            @(negedge clk);
            check("R10", "valid after two edges", {35'd0, out_valid}, 36'd1);
            check(rtag(VEC[v][82:79]), $sformatf("vector %0d", v), out_pix, VEC[v][35:0]);
            @(negedge clk);
        end

        // R10: stream under backpressure, pass-through configuration.
        cfg_red_en = 1'b0; cfg_clamp_mode = 3'd0;
        for (int i = 0; i < 5; i++) stream[i] = {3{12'(12'h111 * (i + 1))}};
        begin
            int sent = 0;
            int recv = 0;
            logic stalled = 1'b0;
            logic [35:0] held = '0;
            logic [7:0] pat = 8'b1011_0010;
            for (int c = 0; c < 200 && recv < 5; c++) begin
                @(negedge clk);
                out_ready = pat[c % 8];
                in_valid  = (sent < 5);
                in_pix    = (sent < 5) ? stream[sent] : '0;
                #1;
                if (stalled) check("R10", "held while stalled", out_pix, held);
                stalled = out_valid && !out_ready;
                held = out_pix;
                if (out_valid && out_ready) begin
                    got[recv] = out_pix;
                    recv++;
                end
                if (in_valid && in_ready) sent++;
            end
            @(negedge clk);
            in_valid = 1'b0; out_ready = 1'b1;
            check("R10", "pixels delivered", 36'(recv), 36'd5);
            for (int i = 0; i < 5; i++)
                check("R10", $sformatf("stream order %0d", i), got[i], stream[i]);
            @(negedge clk);
            @(negedge clk);
            check("R10", "no duplicate after drain", {35'd0, out_valid}, 36'd0);
        end

        // R11: reset in mid-stream empties the stage.
        in_pix = 36'h123456789; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "valid cleared by reset", {35'd0, out_valid}, 36'd0);
        check("R11", "ready after reset", {35'd0, in_ready}, 36'd1);

        finish_run();
    end

endmodule